// File: doc/BRIEF.md
# Serial Port FIFO Interrupt Logic

This block produces the raw, masked and combined interrupt indications for a synchronous serial port with a transmit FIFO and a receive FIFO. It holds both FIFOs, eight entries each, with first-word fall-through read ports. Software or a test harness fills and drains them directly. Received frames enter the receive FIFO as a one-cycle valid pulse with data. A bit-period strobe and a receive-line activity input drive the idle timer.

The four status sources are these. Two are level sources that follow FIFO occupancy. The other two are event sources: the idle timeout and the overrun, and each can be cleared by writing a one to its clear bit. A per-source mask gates each raw bit onto its masked output, and a single interrupt line merges the masked outputs.

Top module: `ssp_irq_ctrl`

## Requirements
- R1: After reset the raw status word `raw_o` is 4'b1000. The bit positions are bit 3 transmit level, bit 2 receive level, bit 1 receive timeout, bit 0 receive overrun.
- R2: `raw_o[3]` is 1 exactly when the transmit FIFO holds four or fewer entries. This bit does not depend on any enable.
- R3: `raw_o[2]` is 1 exactly when the receive FIFO holds four or more entries.
- R4: `raw_o[1]` rises after the 32nd `bit_tick_i` strobe counted while the receive FIFO is non-empty and neither `rx_active_i` nor `rx_frame_valid_i` is high. It is visible the cycle after that strobe.
- R5: `raw_o[1]` is 0 whenever the receive FIFO is empty. A pop that empties the FIFO also restarts the idle count.
- R6: A cycle with `rx_active_i` or `rx_frame_valid_i` high clears `raw_o[1]` from the next cycle on and restarts the idle count from zero.
- R7: Writing `clr_i[1]`=1 clears `raw_o[1]` from the next cycle on and restarts the idle count.
- R8: A frame that arrives while the receive FIFO holds 8 entries sets `raw_o[0]` from the next cycle on. The frame is discarded and the stored entries and their order are unchanged.
- R9: `raw_o[0]` stays set until a cycle with `clr_i[0]`=1. If a new overrun and the clear fall in the same cycle, the overrun wins.
- R10: `clr_i[3]` and `clr_i[2]` have no effect. The level bits always follow occupancy.
- R11: `masked_o` equals `raw_o & mask_i`, and `irq_o` is the OR of `masked_o`.
- R12: Both FIFOs are first-in first-out. A push while full and a pop while empty are ignored. The oldest entry appears on the data output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_push_i | input | 1 | Write one entry into the transmit FIFO |
| tx_data_i | input | 8 | Transmit write data |
| tx_pop_i | input | 1 | Remove the oldest transmit entry |
| tx_data_o | output | 8 | Oldest transmit entry |
| rx_frame_valid_i | input | 1 | Received frame complete, one-cycle pulse |
| rx_frame_data_i | input | 8 | Received frame data |
| rx_pop_i | input | 1 | Remove the oldest receive entry |
| rx_data_o | output | 8 | Oldest receive entry |
| rx_active_i | input | 1 | Receive line activity this cycle |
| bit_tick_i | input | 1 | One strobe per serial bit period |
| clr_i | input | 4 | Write-one-to-clear, same bit positions as raw_o |
| mask_i | input | 4 | Per-source enable, same bit positions as raw_o |
| raw_o | output | 4 | Raw status word |
| masked_o | output | 4 | Raw status AND mask |
| irq_o | output | 1 | OR of masked status |

## Verification
Every state change of this block takes effect at a single clock edge. Occupancy, the timeout flag and the overrun flag are therefore due one cycle after the inputs that cause them. `masked_o` and `irq_o` follow `mask_i` within the same cycle. The timeout bit also drops in the same cycle that the receive FIFO becomes empty. The bench drives inputs on the falling edge and advances its queue-based model by one step per rising edge. It compares all outputs at the next falling edge, which is exactly one register stage after the stimulus.

// File: rtl/ssp_irq_pkg.sv
package ssp_irq_pkg;
  localparam int unsigned NSRC    = 4;
  localparam int unsigned BIT_TX  = 3;
  localparam int unsigned BIT_RX  = 2;
  localparam int unsigned BIT_TMO = 1;
  localparam int unsigned BIT_OVR = 0;
  typedef logic [NSRC-1:0] irq_vec_t;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic push_ok, pop_ok;

  assign push_ok = push_i && (cnt_q != CW'(DEPTH));
  assign pop_ok  = pop_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= wr_q + AW'(1);
      if (pop_ok)  rd_q <= rd_q + AW'(1);
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= data_i;
  end

  assign data_o  = mem_q[rd_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/ssp_rx_idle_timer.sv
module ssp_rx_idle_timer #(
  parameter int unsigned TMO_TICKS = 32,
  localparam int unsigned TW       = $clog2(TMO_TICKS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_empty_i,
  input  logic rx_active_i,
  input  logic frame_i,
  input  logic clr_i,
  input  logic tick_i,
  output logic pend_o
);
  logic [TW-1:0] cnt_q;
  logic          pend_q;
  logic          restart;

  assign restart = rx_empty_i || rx_active_i || frame_i || clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (restart) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (tick_i && !pend_q) begin
      if (cnt_q == TW'(TMO_TICKS - 1)) begin
        cnt_q  <= '0;
        pend_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + TW'(1);
      end
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/ssp_irq_status.sv
module ssp_irq_status
  import ssp_irq_pkg::*;
#(
  parameter int unsigned CW     = 4,
  parameter int unsigned TX_THR = 4,
  parameter int unsigned RX_THR = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic [CW-1:0] tx_cnt_i,
  input  logic [CW-1:0] rx_cnt_i,
  input  logic     tmo_pend_i,
  input  logic     ovr_evt_i,
  input  irq_vec_t clr_i,
  input  irq_vec_t mask_i,
  output irq_vec_t raw_o,
  output irq_vec_t masked_o,
  output logic     irq_o
);
  logic ovr_q;

  // set beats clear so a fresh overrun is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ovr_q <= 1'b0;
    else if (ovr_evt_i)       ovr_q <= 1'b1;
    else if (clr_i[BIT_OVR])  ovr_q <= 1'b0;
  end

  always_comb begin
    raw_o          = '0;
    raw_o[BIT_TX]  = tx_cnt_i <= CW'(TX_THR);
    raw_o[BIT_RX]  = rx_cnt_i >= CW'(RX_THR);
    raw_o[BIT_TMO] = tmo_pend_i && (rx_cnt_i != '0);
    raw_o[BIT_OVR] = ovr_q;
  end

  assign masked_o = raw_o & mask_i;
  assign irq_o    = |masked_o;
endmodule

// File: rtl/ssp_irq_ctrl.sv
module ssp_irq_ctrl
  import ssp_irq_pkg::*;
#(
  parameter int unsigned DW        = 8,
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned TX_THR    = 4,
  parameter int unsigned RX_THR    = 4,
  parameter int unsigned TMO_TICKS = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_push_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_pop_i,
  output logic [DW-1:0] tx_data_o,
  input  logic          rx_frame_valid_i,
  input  logic [DW-1:0] rx_frame_data_i,
  input  logic          rx_pop_i,
  output logic [DW-1:0] rx_data_o,
  input  logic          rx_active_i,
  input  logic          bit_tick_i,
  input  logic [3:0]    clr_i,
  input  logic [3:0]    mask_i,
  output logic [3:0]    raw_o,
  output logic [3:0]    masked_o,
  output logic          irq_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          rx_full, rx_empty, tmo_pend;

  assign rx_full  = rx_cnt == CW'(DEPTH);
  assign rx_empty = rx_cnt == '0;

  ssp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i(tx_push_i), .data_i(tx_data_i), .pop_i(tx_pop_i),
    .data_o(tx_data_o), .count_o(tx_cnt)
  );

  // a frame arriving while full is dropped by the FIFO's own full guard
  ssp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i(rx_frame_valid_i), .data_i(rx_frame_data_i), .pop_i(rx_pop_i),
    .data_o(rx_data_o), .count_o(rx_cnt)
  );

  ssp_rx_idle_timer #(.TMO_TICKS(TMO_TICKS)) u_timer (
    .clk_i, .rst_ni,
    .rx_empty_i(rx_empty), .rx_active_i(rx_active_i), .frame_i(rx_frame_valid_i),
    .clr_i(clr_i[BIT_TMO]), .tick_i(bit_tick_i), .pend_o(tmo_pend)
  );

  ssp_irq_status #(.CW(CW), .TX_THR(TX_THR), .RX_THR(RX_THR)) u_status (
    .clk_i, .rst_ni,
    .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt), .tmo_pend_i(tmo_pend),
    .ovr_evt_i(rx_frame_valid_i && rx_full),
    .clr_i(clr_i), .mask_i(mask_i),
    .raw_o(raw_o), .masked_o(masked_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/ssp_irq_ctrl_chk.sv
module ssp_irq_ctrl_chk #(
  parameter int unsigned CW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_frame_valid_i,
  input logic          rx_pop_i,
  input logic          rx_active_i,
  input logic [3:0]    clr_i,
  input logic [3:0]    raw_o,
  input logic [3:0]    masked_o,
  input logic          irq_o,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          rx_full
);
  // R8
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_frame_valid_i && rx_full |=> raw_o[0]);
  // R8
  ovr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_frame_valid_i && rx_full && !rx_pop_i |=> $stable(rx_cnt));
  // R9
  ovr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_o[0] && !clr_i[0] |=> raw_o[0]);
  // R5
  tmo_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt == '0 |-> !raw_o[1]);
  // R6
  tmo_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_active_i |=> !raw_o[1]);
  // R2
  tx_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_o[3] == (tx_cnt <= CW'(4)));
  // R11
  irq_any_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (masked_o != '0));
endmodule

bind ssp_irq_ctrl ssp_irq_ctrl_chk #(.CW(CW)) u_chk (
  .clk_i, .rst_ni, .rx_frame_valid_i, .rx_pop_i, .rx_active_i, .clr_i,
  .raw_o, .masked_o, .irq_o, .tx_cnt, .rx_cnt, .rx_full
);

// File: tb/sim_ssp_irq_ctrl.sv
`timescale 1ns/1ps
module sim_ssp_irq_ctrl;
  localparam time CLK_P = 10ns;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       tx_push_i = 0, tx_pop_i = 0, rx_frame_valid_i = 0, rx_pop_i = 0;
  logic       rx_active_i = 0, bit_tick_i = 0;
  logic [7:0] tx_data_i = 0, rx_frame_data_i = 0, tx_data_o, rx_data_o;
  logic [3:0] clr_i = 0, mask_i = 0, raw_o, masked_o;
  logic       irq_o;

  always #(CLK_P/2) clk_i = ~clk_i;

  ssp_irq_ctrl u0 (.*);

  int vec = 0, bad = 0;
  bit done = 0;
  string phase = "R1";

  logic [7:0] txq[$], rxq[$];
  int tmo_cnt = 0;
  bit tmo_flag = 0, ovr = 0;

  function automatic logic [3:0] exp_raw();
    return {rxq.size() == 0 ? 1'b0 : 1'b0, 3'b0} |
           {txq.size() <= 4, rxq.size() >= 4, tmo_flag && rxq.size() != 0, ovr};
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    vec++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s (phase %s) got %h expected %h at %0t", req, phase, got, exp, $time);
    end
  endtask

  task automatic compare();
    logic [3:0] e;
    e = exp_raw();
    chk("R2", 8'(raw_o[3]), 8'(e[3]));
    chk("R3", 8'(raw_o[2]), 8'(e[2]));
    chk("R4", 8'(raw_o[1]), 8'(e[1]));
    chk("R8", 8'(raw_o[0]), 8'(e[0]));
    chk("R11", 8'(masked_o), 8'(e & mask_i));
    chk("R11", 8'(irq_o), 8'(|(e & mask_i)));
    if (rxq.size() > 0) chk("R12", rx_data_o, rxq[0]);
    if (txq.size() > 0) chk("R12", tx_data_o, txq[0]);
  endtask

  task automatic model_step();
    bit rfull, rempty;
    rfull  = rxq.size() == 8;
    rempty = rxq.size() == 0;
    if (rempty || rx_active_i || rx_frame_valid_i || clr_i[1]) begin
      tmo_cnt = 0; tmo_flag = 0;
    end else if (bit_tick_i && !tmo_flag) begin
      if (tmo_cnt == 31) begin tmo_flag = 1; tmo_cnt = 0; end
      else tmo_cnt++;
    end
    if (rx_frame_valid_i && rfull) ovr = 1;
    else if (clr_i[0]) ovr = 0;
    begin
      bit tpush, tpop, rpush, rpop;
      tpush = tx_push_i && txq.size() < 8;
      tpop  = tx_pop_i && txq.size() > 0;
      rpush = rx_frame_valid_i && !rfull;
      rpop  = rx_pop_i && !rempty;
      if (tpop) void'(txq.pop_front());
      if (tpush) txq.push_back(tx_data_i);
      if (rpop) void'(rxq.pop_front());
      if (rpush) rxq.push_back(rx_frame_data_i);
    end
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk_i);
    @(negedge clk_i);
    compare();
    tx_push_i = 0; tx_pop_i = 0; rx_frame_valid_i = 0; rx_pop_i = 0;
    rx_active_i = 0; bit_tick_i = 0; clr_i = 0;
  endtask

  task automatic frame(logic [7:0] d);
    rx_frame_valid_i = 1; rx_frame_data_i = d; cyc();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin bit_tick_i = 1; cyc(); end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++;
    $display("FAIL watchdog (phase %s) got timeout expected completion", phase);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1: reset value 4'b1000
    chk("R1", 8'(raw_o), 8'h08);
    @(negedge clk_i);
    compare();

    phase = "R11"; mask_i = 4'hF; cyc();

    // R2 / R12: transmit fill to overflow, then drain past empty
    phase = "R2";
    for (int i = 0; i < 10; i++) begin tx_push_i = 1; tx_data_i = 8'h10 + 8'(i); cyc(); end
    phase = "R12";
    for (int i = 0; i < 10; i++) begin tx_pop_i = 1; cyc(); end
    tx_push_i = 1; tx_pop_i = 1; tx_data_i = 8'h55; cyc();

    // R3: receive level threshold
    phase = "R3";
    for (int i = 0; i < 4; i++) frame(8'h20 + 8'(i));
    rx_pop_i = 1; cyc();
    frame(8'h30);

    // R4: 31 strobes no flag, 32nd sets, gaps in strobes allowed
    phase = "R4";
    ticks(20); cyc(); cyc(); ticks(12); cyc();
    // R6: line activity drops it and restarts the count
    phase = "R6";
    rx_active_i = 1; cyc();
    ticks(31); rx_active_i = 1; cyc(); ticks(31);
    frame(8'h31); ticks(32);
    // R7: clear write
    phase = "R7";
    clr_i = 4'b0010; cyc();
    ticks(32);
    // R10: clears aimed at the level bits change nothing
    phase = "R10";
    clr_i = 4'b1100; cyc(); cyc();
    // R5: draining hides the flag the same cycle and restarts
    phase = "R5";
    while (rxq.size() > 0) begin rx_pop_i = 1; cyc(); end
    frame(8'h40); ticks(32);
    rx_pop_i = 1; cyc(); ticks(5);

    // R8: overrun on full FIFO, contents kept
    phase = "R8";
    for (int i = 0; i < 8; i++) frame(8'h50 + 8'(i));
    frame(8'hEE); cyc();
    rx_frame_valid_i = 1; rx_frame_data_i = 8'hEF; rx_pop_i = 1; cyc();
    // R9: held, set wins over same-cycle clear, then clear
    phase = "R9";
    cyc(); cyc();
    frame(8'h60);
    rx_frame_valid_i = 1; rx_frame_data_i = 8'hE1; clr_i = 4'b0001; cyc();
    clr_i = 4'b0001; cyc();
    cyc();
    phase = "R12";
    while (rxq.size() > 0) begin rx_pop_i = 1; cyc(); end
    rx_pop_i = 1; cyc();

    // R11: mask patterns
    phase = "R11";
    for (int i = 0; i < 4; i++) frame(8'h70 + 8'(i));
    foreach (mask_i[b]) begin mask_i = 4'b1 << b; cyc(); end
    mask_i = 4'b0000; cyc();
    mask_i = 4'b0101; cyc();
    summary();
  end
endmodule